// File: doc/BRIEF.md
# Byte-Serial Register Loader

This block fills a bank of 16-bit registers through an 8-bit data port. A host drives one active-low strobe and two select lines. Each strobe pulse is one load cycle. The falling edge of the strobe fixes the kind of cycle from the select lines: an address cycle, a low-byte cycle or a high-byte cycle. The rising edge of the strobe takes the byte from the data port. The low byte waits in a staging register. A complete 16-bit word goes out only when its high byte arrives, so no half-written value ever reaches a register.

An address cycle also sets the addressing mode. In manual mode the address stays where it was put, so each new target needs its own address cycle. In auto mode the address counter steps up by one after every accepted high byte, so a run of low/high pairs fills consecutive registers from one start address. Address 0 is the status register and addresses 1 to 18 are data registers. A word aimed at any other address is not written out, but the counter still advances in auto mode.

Completed words leave through a valid/ready stream. The block holds one word. While that word is waiting, `ld_ready` is low, and the host must not end a high-byte cycle. A high-byte cycle that ends while the word is still waiting is dropped.

Top module: `lb_loader`

## Requirements
- R1: After synchronous reset, `wr_valid` is 0, `ld_ready` is 1, the mode is manual and the address is 0, so a low/high pair written with no address cycle goes to address 0.
- R2: At the strobe's falling edge the select lines fix the cycle kind: `ld_sel_addr`=1 gives an address cycle; otherwise `ld_sel_hi`=0 gives a low-byte cycle and `ld_sel_hi`=1 gives a high-byte cycle.
- R3: An address cycle takes the address from `ld_data[5:0]` at the rising edge; bits 7:6 are ignored.
- R4: In an address cycle, `ld_sel_hi` at the falling edge picks the mode: 1 selects auto, 0 selects manual. The mode changes only at a falling edge that begins an address cycle.
- R5: A low-byte cycle alone produces no output word. A high-byte cycle emits one word, {high byte, staged low byte}, at the current address.
- R6: In manual mode the address does not change after a high byte, so repeated pairs all write the same address.
- R7: In auto mode the address increments by one after each accepted high byte and never after a low byte.
- R8: A word whose address is above 18 is not emitted, but auto mode still increments the address; the 6-bit address wraps from 63 to 0.
- R9: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr` and `wr_data` hold steady. `ld_ready` equals the inverse of `wr_valid`.
- R10: A high-byte cycle that completes while `ld_ready`=0 is dropped. It emits nothing and leaves the address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_n | input | 1 | Load strobe, active low, idle high |
| ld_sel_addr | input | 1 | Selects an address cycle |
| ld_sel_hi | input | 1 | Selects the high byte; in an address cycle, selects auto mode |
| ld_data | input | 8 | Byte-wide load data |
| ld_ready | output | 1 | Loader can accept a high byte |
| wr_valid | output | 1 | Output word is valid |
| wr_ready | input | 1 | Consumer accepts the output word |
| wr_addr | output | 6 | Target register address |
| wr_data | output | 16 | Target register value |

## Verification
The bench loads words with no address cycle right after reset, with manual addresses that carry stray upper bits, and with isolated low bytes. These cases separate the reset defaults, the masking of the address field and the rule that only a high byte emits a word. Auto runs that start below the top of the data range, and one that starts at address 63, show whether the counter moves only on high bytes and keeps stepping past addresses that have no register, including the wrap to 0. A run with the consumer stalled tells a held output apart from a dropped high byte: the address after the drop must be the one that followed the held word.

// File: rtl/lb_pkg.sv
package lb_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_t;
endpackage

// File: rtl/lb_sync_edge.sv
// Brings the strobe and its companion bus into the clock domain and
// flags the strobe's falling and rising transitions.
module lb_sync_edge #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe_n,
  input  logic [W-1:0] bus,
  output logic         fall,
  output logic         rise,
  output logic [W-1:0] bus_s
);
  localparam int VW = W + 1;
  localparam logic [VW-1:0] IDLE = {1'b1, {W{1'b0}}};

  logic [VW-1:0] stg [STAGES];
  logic          prev_q;

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= IDLE;
    else     stg[0] <= {strobe_n, bus};
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= IDLE;
      else     stg[i] <= stg[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= stg[STAGES-1][W];
  end

  assign fall  =  prev_q & ~stg[STAGES-1][W];
  assign rise  = ~prev_q &  stg[STAGES-1][W];
  assign bus_s =  stg[STAGES-1][W-1:0];

  // R2
  no_double_edge_chk: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/lb_seq.sv
// Cycle-kind latch, address counter, mode bit and low-byte staging.
module lb_seq
  import lb_pkg::*;
#(
  parameter int BW       = 8,
  parameter int AW       = 6,
  parameter int LAST_REG = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fall,
  input  logic            rise,
  input  logic            sel_addr,
  input  logic            sel_hi,
  input  logic [BW-1:0]   data,
  input  logic            accept,
  output logic            push,
  output logic [AW-1:0]   push_addr,
  output logic [2*BW-1:0] push_data
);
  localparam logic [AW-1:0] LAST_A = AW'(LAST_REG);
  localparam logic [AW-1:0] ONE_A  = AW'(1);

  phase_t        phase_q;
  logic          auto_q;
  logic [AW-1:0] addr_q;
  logic [BW-1:0] stage_q;
  logic          hi_done;

  assign hi_done = rise && (phase_q == PH_HI) && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_LO;
      auto_q  <= 1'b0;
      addr_q  <= '0;
      stage_q <= '0;
    end else begin
      if (fall) begin
        if (sel_addr) begin
          phase_q <= PH_ADDR;
          auto_q  <= sel_hi;
        end else begin
          phase_q <= sel_hi ? PH_HI : PH_LO;
        end
      end
      if (rise) begin
        unique case (phase_q)
          PH_ADDR: addr_q  <= data[AW-1:0];
          PH_LO:   stage_q <= data;
          PH_HI:   if (accept && auto_q) addr_q <= addr_q + ONE_A;
          default: ;
        endcase
      end
    end
  end

  assign push      = hi_done && (addr_q <= LAST_A);
  assign push_addr = addr_q;
  assign push_data = {data, stage_q};

  // R4
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(auto_q));
  // R6
  manual_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && phase_q == PH_HI && !auto_q) |=> $stable(addr_q));
  // R7
  auto_step_chk: assert property (@(posedge clk) disable iff (rst)
    (hi_done && auto_q) |=> addr_q == AW'($past(addr_q) + ONE_A));
  // R7
  lo_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && phase_q == PH_LO) |=> $stable(addr_q));
  // R10
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rise && phase_q == PH_HI && !accept) |=> $stable(addr_q));
endmodule

// File: rtl/lb_wr_reg.sv
// One-word output holding register with a valid/ready handshake.
module lb_wr_reg #(
  parameter int AW       = 6,
  parameter int DW       = 16,
  parameter int LAST_REG = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  output logic          can_accept,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (push && !wr_valid) begin
      wr_valid <= 1'b1;
      wr_addr  <= push_addr;
      wr_data  <= push_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assign can_accept = !wr_valid;

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  // R8
  out_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_addr <= AW'(LAST_REG)));
endmodule

// File: rtl/lb_loader.sv
module lb_loader #(
  parameter int BW          = 8,
  parameter int AW          = 6,
  parameter int LAST_REG    = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_n,
  input  logic            ld_sel_addr,
  input  logic            ld_sel_hi,
  input  logic [BW-1:0]   ld_data,
  output logic            ld_ready,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [AW-1:0]   wr_addr,
  output logic [2*BW-1:0] wr_data
);
  localparam int DW = 2 * BW;
  localparam int SW = BW + 2;

  logic          fall, rise, sel_addr_s, sel_hi_s, accept, push;
  logic [BW-1:0] data_s;
  logic [AW-1:0] push_addr;
  logic [DW-1:0] push_data;

  lb_sync_edge #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .strobe_n(ld_n),
    .bus({ld_sel_addr, ld_sel_hi, ld_data}),
    .fall(fall), .rise(rise),
    .bus_s({sel_addr_s, sel_hi_s, data_s})
  );

  lb_seq #(.BW(BW), .AW(AW), .LAST_REG(LAST_REG)) u_seq (
    .clk(clk), .rst(rst), .fall(fall), .rise(rise),
    .sel_addr(sel_addr_s), .sel_hi(sel_hi_s), .data(data_s),
    .accept(accept), .push(push), .push_addr(push_addr), .push_data(push_data)
  );

  lb_wr_reg #(.AW(AW), .DW(DW), .LAST_REG(LAST_REG)) u_out (
    .clk(clk), .rst(rst), .push(push), .push_addr(push_addr),
    .push_data(push_data), .can_accept(accept),
    .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign ld_ready = accept;

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(rst) |-> !wr_valid);
endmodule

// File: tb/sim_lb_loader.sv
module sim_lb_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_n = 1'b1, ld_sel_addr = 1'b0, ld_sel_hi = 1'b0;
  logic [7:0]  ld_data = 8'h00;
  logic        ld_ready, wr_valid, wr_addr_unused;
  logic        wr_ready = 1'b1;
  logic [5:0]  wr_addr;
  logic [15:0] wr_data;
  int n_chk = 0, n_bad = 0;
  logic [21:0] exp_q[$];
  bit done = 0;

  always #2 clk = ~clk;

  lb_loader u0 (
    .clk(clk), .rst(rst), .ld_n(ld_n), .ld_sel_addr(ld_sel_addr),
    .ld_sel_hi(ld_sel_hi), .ld_data(ld_data), .ld_ready(ld_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );
  assign wr_addr_unused = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input bit sa, input bit sh, input logic [7:0] d);
    @(negedge clk);
    ld_sel_addr = sa; ld_sel_hi = sh; ld_data = d; ld_n = 1'b0;
    repeat (4) @(negedge clk);
    ld_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_addr(input logic [7:0] a, input bit auto_m);
    pulse(1'b1, auto_m, a);
  endtask

  task automatic pair(input logic [7:0] lo, input logic [7:0] hi);
    pulse(1'b0, 1'b0, lo);
    pulse(1'b0, 1'b1, hi);
  endtask

  task automatic expect_w(input logic [5:0] a, input logic [15:0] d);
    exp_q.push_back({a, d});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wr_valid && wr_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R8 unexpected word", int'({wr_addr, wr_data}), 0);
      end else begin
        logic [21:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, "R5 word", int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(wr_valid == 1'b0, "R1 wr_valid", int'(wr_valid), 0);
    check(ld_ready == 1'b1, "R1 ld_ready", int'(ld_ready), 1);
    // R1 / R6: no address cycle, manual at address 0
    expect_w(6'd0, 16'h1234); pair(8'h34, 8'h12);
    expect_w(6'd0, 16'h5678); pair(8'h78, 8'h56);
    // R3 / R2: upper address bits ignored
    set_addr(8'hC5, 1'b0);
    expect_w(6'd5, 16'hABCD); pair(8'hCD, 8'hAB);
    // R5: low byte alone emits nothing
    pulse(1'b0, 1'b0, 8'h11);
    check(wr_valid == 1'b0, "R5 low byte alone", int'(wr_valid), 0);
    expect_w(6'd5, 16'h2211); pulse(1'b0, 1'b1, 8'h22);
    // R7 / R8: auto run across the top of the data range
    set_addr(8'd16, 1'b1);
    expect_w(6'd16, 16'h0102); pair(8'h02, 8'h01);
    expect_w(6'd17, 16'h0304); pair(8'h04, 8'h03);
    expect_w(6'd18, 16'h0506); pair(8'h06, 8'h05);
    pair(8'h08, 8'h07);            // R8 address 19 dropped
    // R4: manual mode ends auto stepping
    set_addr(8'd2, 1'b0);
    expect_w(6'd2, 16'h0A09); pair(8'h09, 8'h0A);
    expect_w(6'd2, 16'h0C0B); pair(8'h0B, 8'h0C);
    // R8: wrap from 63 to 0 in auto mode
    set_addr(8'd63, 1'b1);
    pair(8'h0D, 8'h0E);
    expect_w(6'd0, 16'h1E1F); pair(8'h1F, 8'h1E);
    // R9 / R10: stalled consumer
    set_addr(8'd5, 1'b1);
    wr_ready = 1'b0;
    expect_w(6'd5, 16'hBEEF); pair(8'hEF, 8'hBE);
    check(wr_valid == 1'b1, "R9 held valid", int'(wr_valid), 1);
    check(ld_ready == 1'b0, "R9 ld_ready low", int'(ld_ready), 0);
    pair(8'h44, 8'h33);            // R10 dropped, address stays 6
    check(wr_addr == 6'd5 && wr_data == 16'hBEEF, "R9 held word",
          int'({wr_addr, wr_data}), int'({6'd5, 16'hBEEF}));
    wr_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(ld_ready == 1'b1, "R9 ld_ready back", int'(ld_ready), 1);
    expect_w(6'd6, 16'h6655); pair(8'h55, 8'h66);   // R10 no step on drop
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule